// File: doc/BRIEF.md
# Video DMA Interrupt and Command Controller

This block sits between a register bus and up to eight video DMA channel engines. Each engine reports a one-cycle frame-completed pulse and a one-cycle error pulse. The controller latches these pulses into a single interrupt status word and drives one level-sensitive interrupt line. Software drains the status word with a read that returns the pending events and clears them in the same access. An event that arrives during that read is not lost. It is kept for the next read.

The controller also holds the run controls for the channels. A command word carries a global run bit and one run bit per channel. A separate enable word decides which channels may run at all. To restart a stuck channel engine, software clears that channel's command bit and then sets it again. The second write produces a one-cycle reset pulse to that engine and discards the channel's pending events.

Two read-only words report live FIFO and parser conditions from the engines. Two plain storage words hold timer settings that other logic uses.

Top module: `vdma_irq_ctrl`

Word address map: 0 interrupt status, 1 command, 2 channel enable, 3 FIFO conditions, 4 parser conditions, 5 timer interval, 6 channel timeout. Address 7 is unmapped.

## Requirements
- R1: After reset the following are all zero: irq, ch_run, ch_reset, the status word and the command word.
- R2: A frame_done pulse on channel c sets status bit c. A dma_err pulse on channel c sets status bit 24+c. Each bit stays set until it is cleared.
- R3: A read of address 0 returns the pending status on bus_rdata in the cycle after the strobe and clears the status. A read right after it returns 0.
- R4: An event that arrives in the same cycle as a status read is left out of that read's data. It is returned by the next read.
- R5: irq is high when any pending done or error bit belongs to a channel whose enable bit is set. Bits of disabled channels do not raise it. irq falls in the cycle after a clearing read when no new event is pending.
- R6: ch_run[c] is the AND of command bit 31, command bit c and enable bit c. Writing 0 to the command word stops every channel.
- R7: Setting a command channel bit raises ch_reset[c] for exactly one cycle, in the cycle after the write, but only when an earlier write cleared that bit from 1 to 0. Setting a bit for the first time does not raise it, and neither does rewriting a bit that is already 1.
- R8: A ch_reset pulse on channel c clears status bits c and 24+c. It leaves the bits of other channels unchanged.
- R9: Address 3 reads fifo_lo[c] at bit c, fifo_mid[c] at bit 16+c and fifo_hi[c] at bit 24+c. Address 4 reads parse_lo[c] at bit c and parse_hi[c] at bit 8+c. All other bits of these two words read 0.
- R10: Addresses 5 and 6 read back the last value written to them. Writes to addresses 0, 3 and 4 change nothing. Address 7 reads 0.
- R11: Address 1 reads back bit 31 and the channel bits of the command word, with every other bit 0. Address 2 reads back the channel enable bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | AW | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle after bus_rd |
| frame_done | input | NCH | Per-channel frame-completed pulses |
| dma_err | input | NCH | Per-channel DMA error pulses |
| fifo_lo | input | NCH | FIFO condition reported at bit c |
| fifo_mid | input | NCH | FIFO condition reported at bit 16+c |
| fifo_hi | input | NCH | FIFO condition reported at bit 24+c |
| parse_lo | input | NCH | Parser condition reported at bit c |
| parse_hi | input | NCH | Parser condition reported at bit 8+c |
| irq | output | 1 | Level interrupt |
| ch_run | output | NCH | Effective per-channel run |
| ch_reset | output | NCH | One-cycle per-channel engine reset |

## Verification
Read data, status updates and ch_reset each pass through one register. They are due at the first clock edge after the strobe or event. irq and ch_run are decoded from registers without further delay, so they change at that same edge. Every bench task drives its inputs on a falling edge and samples at the next falling edge, which lands exactly one rising edge after the stimulus. The task that checks R8 waits one extra falling edge, because the status clears on the edge that follows the reset pulse.

// File: rtl/vdma_irq_ctrl.sv
module vdma_irq_ctrl #(
  parameter int NCH = 8,
  parameter int AW  = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_wr,
  input  logic           bus_rd,
  input  logic [AW-1:0]  bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  input  logic [NCH-1:0] frame_done,
  input  logic [NCH-1:0] dma_err,
  input  logic [NCH-1:0] fifo_lo,
  input  logic [NCH-1:0] fifo_mid,
  input  logic [NCH-1:0] fifo_hi,
  input  logic [NCH-1:0] parse_lo,
  input  logic [NCH-1:0] parse_hi,
  output logic           irq,
  output logic [NCH-1:0] ch_run,
  output logic [NCH-1:0] ch_reset
);
  localparam int RUN_BIT = 31;
  localparam int ERR_LSB = 24;
  localparam int FMID_LSB = 16;
  localparam int FHI_LSB = 24;
  localparam int PHI_LSB = 8;
  localparam logic [AW-1:0] A_STAT = AW'(0);
  localparam logic [AW-1:0] A_CMD  = AW'(1);
  localparam logic [AW-1:0] A_EN   = AW'(2);
  localparam logic [AW-1:0] A_FIFO = AW'(3);
  localparam logic [AW-1:0] A_PARS = AW'(4);
  localparam logic [AW-1:0] A_TMR  = AW'(5);
  localparam logic [AW-1:0] A_TMO  = AW'(6);

  logic [NCH-1:0] done_q, err_q, cmd_ch_q, en_q, armed_q, rst_q;
  logic           run_q;
  logic [31:0]    tmr_q, tmo_q, rd_mux;

  wire            stat_rd = bus_rd && (bus_addr == A_STAT);
  wire            cmd_wr  = bus_wr && (bus_addr == A_CMD);
  wire [NCH-1:0]  cmd_new = bus_wdata[NCH-1:0];
  wire [NCH-1:0]  rising  = cmd_new & ~cmd_ch_q;
  wire [NCH-1:0]  falling = cmd_ch_q & ~cmd_new;

  always_comb begin
    rd_mux = '0;
    case (bus_addr)
      A_STAT: for (int i = 0; i < NCH; i++) begin
        rd_mux[i] = done_q[i];
        rd_mux[ERR_LSB+i] = err_q[i];
      end
      A_CMD: begin
        rd_mux[NCH-1:0] = cmd_ch_q;
        rd_mux[RUN_BIT] = run_q;
      end
      A_EN: rd_mux[NCH-1:0] = en_q;
      A_FIFO: for (int i = 0; i < NCH; i++) begin
        rd_mux[i] = fifo_lo[i];
        rd_mux[FMID_LSB+i] = fifo_mid[i];
        rd_mux[FHI_LSB+i] = fifo_hi[i];
      end
      A_PARS: for (int i = 0; i < NCH; i++) begin
        rd_mux[i] = parse_lo[i];
        rd_mux[PHI_LSB+i] = parse_hi[i];
      end
      A_TMR: rd_mux = tmr_q;
      A_TMO: rd_mux = tmo_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q    <= '0;
      err_q     <= '0;
      cmd_ch_q  <= '0;
      run_q     <= 1'b0;
      en_q      <= '0;
      armed_q   <= '0;
      rst_q     <= '0;
      tmr_q     <= '0;
      tmo_q     <= '0;
      bus_rdata <= '0;
    end else begin
      done_q <= ((stat_rd ? '0 : done_q) & ~rst_q) | frame_done;
      err_q  <= ((stat_rd ? '0 : err_q) & ~rst_q) | dma_err;
      rst_q  <= cmd_wr ? (armed_q & rising) : '0;
      if (cmd_wr) begin
        run_q    <= bus_wdata[RUN_BIT];
        cmd_ch_q <= cmd_new;
        armed_q  <= (armed_q & ~rising) | falling;
      end
      if (bus_wr && bus_addr == A_EN)  en_q  <= bus_wdata[NCH-1:0];
      if (bus_wr && bus_addr == A_TMR) tmr_q <= bus_wdata;
      if (bus_wr && bus_addr == A_TMO) tmo_q <= bus_wdata;
      if (bus_rd) bus_rdata <= rd_mux;
    end
  end

  assign irq      = |((done_q | err_q) & en_q);
  assign ch_run   = cmd_ch_q & en_q & {NCH{run_q}};
  assign ch_reset = rst_q;
endmodule

module vdma_irq_ctrl_chk #(
  parameter int NCH = 8,
  parameter int AW  = 3
) (
  input logic           clk,
  input logic           rst_n,
  input logic           bus_rd,
  input logic [AW-1:0]  bus_addr,
  input logic [NCH-1:0] frame_done,
  input logic [NCH-1:0] dma_err,
  input logic           irq,
  input logic [NCH-1:0] ch_run,
  input logic [NCH-1:0] ch_reset,
  input logic [NCH-1:0] done_q,
  input logic [NCH-1:0] err_q,
  input logic [NCH-1:0] en_q
);
  assert_event_latched_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (|frame_done) |=> ((done_q & $past(frame_done)) == $past(frame_done)));

  assert_read_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0 && !(|frame_done) && !(|dma_err)) |=> (done_q == '0 && err_q == '0));

  assert_irq_drops_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == '0 && !(|frame_done) && !(|dma_err)) |=> !irq);

  assert_run_gated_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ((ch_run & ~en_q) == '0));

  assert_reset_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (|ch_reset) |=> ((ch_reset & $past(ch_reset)) == '0));

  assert_reset_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ((|ch_reset) && !(|frame_done) && !(|dma_err)) |=> (((done_q | err_q) & $past(ch_reset)) == '0));
endmodule

bind vdma_irq_ctrl vdma_irq_ctrl_chk #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .frame_done(frame_done), .dma_err(dma_err), .irq(irq), .ch_run(ch_run),
  .ch_reset(ch_reset), .done_q(done_q), .err_q(err_q), .en_q(en_q)
);

// File: tb/vdma_irq_ctrl_test.sv
module vdma_irq_ctrl_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  frame_done = '0, dma_err = '0;
  logic [7:0]  fifo_lo = '0, fifo_mid = '0, fifo_hi = '0, parse_lo = '0, parse_hi = '0;
  logic        irq;
  logic [7:0]  ch_run, ch_reset;
  int checks = 0, failures = 0;
  logic [31:0] d;

  always #2 clk = ~clk;

  vdma_irq_ctrl #(.NCH(8), .AW(3)) uut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .frame_done(frame_done), .dma_err(dma_err),
    .fifo_lo(fifo_lo), .fifo_mid(fifo_mid), .fifo_hi(fifo_hi), .parse_lo(parse_lo),
    .parse_hi(parse_hi), .irq(irq), .ch_run(ch_run), .ch_reset(ch_reset)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] v);
    @(negedge clk); bus_wr = 1'b1; bus_addr = a; bus_wdata = v;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] v);
    @(negedge clk); bus_rd = 1'b1; bus_addr = a;
    @(negedge clk); bus_rd = 1'b0; v = bus_rdata;
  endtask

  task automatic ev(input logic [7:0] dn, input logic [7:0] er);
    @(negedge clk); frame_done = dn; dma_err = er;
    @(negedge clk); frame_done = '0; dma_err = '0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1 irq", {31'b0, irq}, 32'h0);
    chk("R1 ch_run", {24'b0, ch_run}, 32'h0);
    chk("R1 ch_reset", {24'b0, ch_reset}, 32'h0);
    rd(3'd0, d); chk("R1 status", d, 32'h0);
    rd(3'd1, d); chk("R1 command", d, 32'h0);
  endtask

  task automatic t_latch();
    do_reset();
    ev(8'h05, 8'h80);
    repeat (3) @(negedge clk);
    rd(3'd0, d); chk("R2 latched status", d, 32'h8000_0005);
    rd(3'd0, d); chk("R3 cleared by read", d, 32'h0);
  endtask

  task automatic t_coincide();
    do_reset();
    ev(8'h01, 8'h00);
    @(negedge clk); bus_rd = 1'b1; bus_addr = 3'd0; frame_done = 8'h02;
    @(negedge clk); bus_rd = 1'b0; frame_done = '0; d = bus_rdata;
    chk("R4 read excludes same-cycle event", d, 32'h0000_0001);
    rd(3'd0, d); chk("R4 same-cycle event kept", d, 32'h0000_0002);
  endtask

  task automatic t_irq();
    do_reset();
    wr(3'd2, 32'h01);
    chk("R5 irq idle", {31'b0, irq}, 32'h0);
    ev(8'h04, 8'h00);
    chk("R5 disabled channel no irq", {31'b0, irq}, 32'h0);
    ev(8'h00, 8'h01);
    chk("R5 enabled error raises irq", {31'b0, irq}, 32'h1);
    rd(3'd0, d);
    chk("R3 read data", d, 32'h0100_0004);
    chk("R5 irq drops after read", {31'b0, irq}, 32'h0);
  endtask

  task automatic t_run();
    do_reset();
    wr(3'd2, 32'h0F);
    wr(3'd1, 32'h8000_0033);
    chk("R6 run gated by enable", {24'b0, ch_run}, 32'h03);
    rd(3'd1, d); chk("R11 command readback", d, 32'h8000_0033);
    rd(3'd2, d); chk("R11 enable readback", d, 32'h0F);
    wr(3'd1, 32'h0000_0033);
    chk("R6 global run off", {24'b0, ch_run}, 32'h0);
    wr(3'd1, 32'h8000_0033);
    wr(3'd1, 32'h0);
    chk("R6 write zero stops all", {24'b0, ch_run}, 32'h0);
    wr(3'd1, 32'hFFFF_FFFF);
    rd(3'd1, d); chk("R11 unused command bits read 0", d, 32'h8000_00FF);
  endtask

  task automatic t_toggle();
    do_reset();
    wr(3'd1, 32'h8000_0001);
    chk("R7 first set no pulse", {24'b0, ch_reset}, 32'h0);
    wr(3'd1, 32'h8000_0001);
    chk("R7 rewrite 1 no pulse", {24'b0, ch_reset}, 32'h0);
    wr(3'd1, 32'h8000_0000);
    chk("R7 clear no pulse", {24'b0, ch_reset}, 32'h0);
    wr(3'd1, 32'h8000_0001);
    chk("R7 toggle pulse", {24'b0, ch_reset}, 32'h01);
    @(negedge clk);
    chk("R7 pulse one cycle", {24'b0, ch_reset}, 32'h0);
    wr(3'd1, 32'h8000_0001);
    chk("R7 no second pulse", {24'b0, ch_reset}, 32'h0);
  endtask

  task automatic t_rstclr();
    do_reset();
    wr(3'd1, 32'h3);
    wr(3'd1, 32'h0);
    ev(8'h03, 8'h03);
    wr(3'd1, 32'h1);
    chk("R7 pulse on ch0 only", {24'b0, ch_reset}, 32'h01);
    @(negedge clk);
    rd(3'd0, d); chk("R8 only ch0 cleared", d, 32'h0200_0002);
  endtask

  task automatic t_ro();
    do_reset();
    fifo_lo = 8'h01; fifo_mid = 8'h80; fifo_hi = 8'h10;
    parse_lo = 8'h02; parse_hi = 8'h40;
    rd(3'd3, d); chk("R9 fifo mapping", d, 32'h1080_0001);
    rd(3'd4, d); chk("R9 parser mapping", d, 32'h0000_4002);
    fifo_lo = '0; fifo_mid = '0; fifo_hi = '0; parse_lo = '0; parse_hi = '0;
  endtask

  task automatic t_hold();
    do_reset();
    wr(3'd5, 32'h0003_8000);
    wr(3'd6, 32'h3EFF_0FF0);
    rd(3'd5, d); chk("R10 timer hold", d, 32'h0003_8000);
    rd(3'd6, d); chk("R10 timeout hold", d, 32'h3EFF_0FF0);
    ev(8'h08, 8'h00);
    wr(3'd0, 32'hFFFF_FFFF);
    wr(3'd3, 32'h0);
    wr(3'd4, 32'hFFFF_FFFF);
    rd(3'd0, d); chk("R10 status writes ignored", d, 32'h0000_0008);
    rd(3'd7, d); chk("R10 unmapped reads 0", d, 32'h0);
  endtask

  initial begin
    #400000;
    checks++; failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    t_reset();
    t_latch();
    t_coincide();
    t_irq();
    t_run();
    t_toggle();
    t_rstclr();
    t_ro();
    t_hold();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule